// File: doc/BRIEF.md
# Dual-Loop Digital Lock Detector

This block decides, for each of several phase-locked loops, whether the loop is in lock, and combines the per-loop verdicts into one overall lock flag. Each loop supplies a strobe that marks one reference-clock cycle and a flag, valid with that strobe, that says whether the phase comparison in that cycle showed a large error. The block reads only these two signals. The discriminator that produces the flag stays outside.

The decision uses asymmetric hysteresis. An unlocked loop becomes locked only after an unbroken run of clean reference cycles, and any single large error restarts that run. A locked loop keeps an up/down tally: an error cycle adds one, a clean cycle takes one away, and the tally never drops below zero. The loop falls out of lock when the tally reaches the release threshold. A restart input, pulsed when a new frequency acquisition begins, puts every loop back into the unlocked state with cleared counters. The overall flag is high only while every loop is locked.

Top module: `lock_detect_top`

## Requirements
- R1: A loop's lock state and counters change only in cycles where its ref_tick is high or restart is high. Cycles without a strobe are ignored.
- R2: An unlocked loop becomes locked after ACQ_RUN consecutive strobed cycles with big_err low (default 256). loop_locked rises in the cycle after the edge that samples the ACQ_RUN-th clean strobe.
- R3: While unlocked, a strobed cycle with big_err high sets the clean-run count back to zero. A full ACQ_RUN clean strobes are then needed again.
- R4: While locked, a strobed error adds one to the net count. A strobed clean cycle subtracts one, but only when the count is above zero. Clean cycles at zero build up no credit.
- R5: A locked loop becomes unlocked on the strobed error that brings the net count to LOSS_NET (default 256).
- R6: On entering lock, the net count starts at zero. On leaving lock, the clean-run count starts at zero, so relocking needs a full ACQ_RUN clean run.
- R7: all_locked is high exactly when every bit of loop_locked is high.
- R8: restart forces every loop unlocked and clears both counters on the next edge. It takes priority over a strobe in the same cycle.
- R9: Each loop's verdict depends only on its own ref_tick and big_err bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; strobes are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| restart | input | 1 | Begins a new acquisition: clears all loops |
| ref_tick | input | NUM_LOOPS | Per-loop one-cycle strobe marking one reference cycle |
| big_err | input | NUM_LOOPS | Per-loop large-phase-error flag, valid with ref_tick |
| loop_locked | output | NUM_LOOPS | Per-loop lock verdict |
| all_locked | output | 1 | High only while every loop is locked |

## Verification
The hardest state to reach is a loss of lock caused by the up/down tally rather than by a plain run of errors. To show that the tally counts down, and that it does not go below zero, the stimulus first holds a locked loop through hundreds of clean strobes while the other loop acquires. It then applies one error fewer than the threshold, one clean strobe, and two more errors. Lock must drop exactly on the last of these. Any banked credit, or a missing down-count, moves that edge. The restart checks drop restart into the middle of a partial clean run, and into a cycle that also carries a strobe, so that a stale run count would show up as an early relock.

// File: rtl/lock_detect_pkg.sv
package lock_detect_pkg;

    // Event seen by one loop tracker in a given cycle
    typedef enum logic [1:0] {
        EV_NONE  = 2'd0,
        EV_CLEAN = 2'd1,
        EV_ERROR = 2'd2,
        EV_CLEAR = 2'd3
    } loop_event_e;

    // Maximum supported counter width
    localparam int unsigned CNT_W_MAX = 16;

    typedef struct packed {
        logic                 locked;
        logic [CNT_W_MAX-1:0] run_cnt;
        logic [CNT_W_MAX-1:0] net_cnt;
    } tracker_state_t;

endpackage

// File: rtl/loop_event_decode.sv
module loop_event_decode
    import lock_detect_pkg::*;
(
    input  logic        restart,
    input  logic        tick,
    input  logic        err,
    output loop_event_e evt
);
    always_comb begin
        if (restart) begin
            evt = EV_CLEAR;
        end else if (!tick) begin
            evt = EV_NONE;
        end else if (err) begin
            evt = EV_ERROR;
        end else begin
            evt = EV_CLEAN;
        end
    end
endmodule

// File: rtl/loop_lock_tracker.sv
module loop_lock_tracker
    import lock_detect_pkg::*;
#(
    parameter int unsigned ACQ_RUN  = 256,
    parameter int unsigned LOSS_NET = 256
) (
    input  logic        clk,
    input  logic        rst_n,
    input  loop_event_e evt,
    output logic        locked
);
    localparam logic [CNT_W_MAX-1:0] RUN_LAST = CNT_W_MAX'(ACQ_RUN - 1);
    localparam logic [CNT_W_MAX-1:0] NET_LAST = CNT_W_MAX'(LOSS_NET - 1);

    tracker_state_t st_q;
    tracker_state_t st_d;

    always_comb begin
        st_d = st_q;
        unique case (evt)
            EV_CLEAR: begin
                st_d.locked  = 1'b0;
                st_d.run_cnt = '0;
                st_d.net_cnt = '0;
            end
            EV_CLEAN: begin
                if (!st_q.locked) begin
                    if (st_q.run_cnt == RUN_LAST) begin
                        st_d.locked  = 1'b1;
                        st_d.run_cnt = '0;
                        st_d.net_cnt = '0;
                    end else begin
                        st_d.run_cnt = st_q.run_cnt + 1'b1;
                    end
                end else if (st_q.net_cnt != '0) begin
                    st_d.net_cnt = st_q.net_cnt - 1'b1;
                end
            end
            EV_ERROR: begin
                if (!st_q.locked) begin
                    st_d.run_cnt = '0;
                end else if (st_q.net_cnt == NET_LAST) begin
                    st_d.locked  = 1'b0;
                    st_d.run_cnt = '0;
                    st_d.net_cnt = '0;
                end else begin
                    st_d.net_cnt = st_q.net_cnt + 1'b1;
                end
            end
            default: begin
                st_d = st_q;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign locked = st_q.locked;
endmodule

// File: rtl/lock_and_reduce.sv
module lock_and_reduce #(
    parameter int unsigned WIDTH = 2
) (
    input  logic [WIDTH-1:0] in_vec,
    output logic             all_set
);
    logic [WIDTH:0] chain;
    assign chain[0] = 1'b1;
    for (genvar i = 0; i < WIDTH; i++) begin : g_and
        assign chain[i+1] = chain[i] & in_vec[i];
    end
    assign all_set = chain[WIDTH];
endmodule

// File: rtl/lock_detect_top.sv
module lock_detect_top
    import lock_detect_pkg::*;
#(
    parameter int unsigned NUM_LOOPS = 2,
    parameter int unsigned ACQ_RUN   = 256,
    parameter int unsigned LOSS_NET  = 256
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 restart,
    input  logic [NUM_LOOPS-1:0] ref_tick,
    input  logic [NUM_LOOPS-1:0] big_err,
    output logic [NUM_LOOPS-1:0] loop_locked,
    output logic                 all_locked
);
    for (genvar i = 0; i < NUM_LOOPS; i++) begin : g_loop
        loop_event_e evt;

        loop_event_decode dec_i (
            .restart (restart),
            .tick    (ref_tick[i]),
            .err     (big_err[i]),
            .evt     (evt)
        );

        loop_lock_tracker #(
            .ACQ_RUN  (ACQ_RUN),
            .LOSS_NET (LOSS_NET)
        ) trk_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .evt    (evt),
            .locked (loop_locked[i])
        );
    end

    lock_and_reduce #(
        .WIDTH (NUM_LOOPS)
    ) red_i (
        .in_vec  (loop_locked),
        .all_set (all_locked)
    );
endmodule

// File: rtl/lock_detect_chk.sv
module lock_detect_chk #(
    parameter int unsigned NUM_LOOPS = 2
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 restart,
    input logic [NUM_LOOPS-1:0] ref_tick,
    input logic [NUM_LOOPS-1:0] big_err,
    input logic [NUM_LOOPS-1:0] loop_locked,
    input logic                 all_locked
);
    // R8
    restart_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (loop_locked == '0 && !all_locked));

    for (genvar i = 0; i < NUM_LOOPS; i++) begin : g_chk
        // R1
        idle_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!restart && !ref_tick[i]) |=> $stable(loop_locked[i]));

        // R2
        rise_on_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(loop_locked[i]) |-> $past(ref_tick[i] && !big_err[i] && !restart));

        // R5
        fall_on_error_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(loop_locked[i]) |-> $past(restart || (ref_tick[i] && big_err[i])));
    end
endmodule

bind lock_detect_top lock_detect_chk #(
    .NUM_LOOPS (NUM_LOOPS)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .restart     (restart),
    .ref_tick    (ref_tick),
    .big_err     (big_err),
    .loop_locked (loop_locked),
    .all_locked  (all_locked)
);

// File: tb/lock_detect_top_tb_top.sv
module lock_detect_top_tb_top;
    localparam int NL = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          restart = 1'b0;
    logic [NL-1:0] ref_tick = '0;
    logic [NL-1:0] big_err = '0;
    logic [NL-1:0] loop_locked;
    logic          all_locked;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    typedef struct {
        logic [NL-1:0] lk;
        logic          all;
        string         tag;
    } exp_t;

    exp_t sb_q[$];

    always #10 clk = ~clk;

    lock_detect_top dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .restart     (restart),
        .ref_tick    (ref_tick),
        .big_err     (big_err),
        .loop_locked (loop_locked),
        .all_locked  (all_locked)
    );

    // Monitor: compares outputs a quarter period after each edge
    always @(posedge clk) begin
        #5;
        if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            total++;
            if (loop_locked !== e.lk || all_locked !== e.all) begin
                bad++;
                $display("FAIL %s: locked=%b all=%b expected locked=%b all=%b",
                         e.tag, loop_locked, all_locked, e.lk, e.all);
            end
        end
    end

    // Driver: one cycle of stimulus and the outputs expected after it
    task automatic cyc(input logic [NL-1:0] t, input logic [NL-1:0] er,
                       input logic rs, input logic [NL-1:0] lk, input string tag);
        exp_t e;
        @(negedge clk);
        ref_tick = t;
        big_err  = er;
        restart  = rs;
        e.lk  = lk;
        e.all = &lk;
        e.tag = tag;
        sb_q.push_back(e);
    endtask

    task automatic idle(input logic [NL-1:0] lk, input string tag);
        cyc('0, '0, 1'b0, lk, tag);
    endtask

    initial begin
        #(20 * 200000);
        total++;
        bad++;
        $display("FAIL watchdog: locked=%b expected run to finish", loop_locked);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        total++;
        if (loop_locked !== 2'b00 || all_locked !== 1'b0) begin
            bad++;
            $display("FAIL reset: locked=%b all=%b expected 00/0", loop_locked, all_locked);
        end
        rst_n = 1'b1;

        // R1: no strobes, nothing happens
        for (int i = 0; i < 300; i++) idle(2'b00, "R1 idle");

        // R2, R3, R9: loop0 runs clean with gaps, loop1 sees errors throughout
        for (int i = 0; i < 255; i++) begin
            cyc(2'b11, 2'b10, 1'b0, 2'b00, "R2 partial run");
            idle(2'b00, "R1 gap");
        end
        cyc(2'b11, 2'b11, 1'b0, 2'b00, "R3 error resets run");
        for (int i = 0; i < 255; i++) cyc(2'b11, 2'b10, 1'b0, 2'b00, "R3 rerun");
        cyc(2'b11, 2'b10, 1'b0, 2'b01, "R2 R9 loop0 locks");
        for (int i = 0; i < 5; i++) idle(2'b01, "R1 hold lock");

        // R7: loop1 acquires; loop0 clean ticks at zero bank no credit (R4)
        for (int i = 0; i < 255; i++) cyc(2'b11, 2'b00, 1'b0, 2'b01, "R4 R7 one locked");
        cyc(2'b11, 2'b00, 1'b0, 2'b11, "R7 both locked");

        // R4, R5: net up/down count on loop0
        for (int i = 0; i < 255; i++) cyc(2'b01, 2'b01, 1'b0, 2'b11, "R4 errors below limit");
        cyc(2'b01, 2'b00, 1'b0, 2'b11, "R4 clean counts down");
        cyc(2'b01, 2'b01, 1'b0, 2'b11, "R4 net back to 255");
        cyc(2'b01, 2'b01, 1'b0, 2'b10, "R5 loss at net limit");

        // R6: relock needs a full clean run
        for (int i = 0; i < 255; i++) cyc(2'b01, 2'b00, 1'b0, 2'b10, "R6 relock run");
        cyc(2'b01, 2'b00, 1'b0, 2'b11, "R6 relocked");

        // R6: net starts at zero after relock, so 255 errors keep lock
        for (int i = 0; i < 255; i++) cyc(2'b01, 2'b01, 1'b0, 2'b11, "R6 fresh net");
        cyc(2'b01, 2'b01, 1'b0, 2'b10, "R5 second loss");

        // R8: restart beats a same-cycle strobe and clears partial runs
        cyc(2'b11, 2'b00, 1'b1, 2'b00, "R8 restart with tick");
        for (int i = 0; i < 200; i++) cyc(2'b11, 2'b00, 1'b0, 2'b00, "R8 partial run");
        cyc(2'b00, 2'b00, 1'b1, 2'b00, "R8 restart mid run");
        for (int i = 0; i < 255; i++) cyc(2'b11, 2'b00, 1'b0, 2'b00, "R8 run after restart");
        cyc(2'b11, 2'b00, 1'b0, 2'b11, "R8 R7 both lock");
        idle(2'b11, "R1 idle locked");

        repeat (3) @(negedge clk);
        ref_tick = '0;
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule